// File: doc/BRIEF.md
# Brownout Reset Pulse Stretcher

This block is the digital half of a supply supervisor. An external comparator raises a flag while the supply is under its trip point. The block turns that flag into a system reset. It first passes the flag through a two-flop synchronizer. It then ignores dips too short to matter. Once a dip has lasted long enough, it asserts reset. After the supply has recovered, it keeps reset asserted for a long hold time.

The block leaves power-on clear with reset already asserted. It then runs one hold period before the first release. All time spans are whole clock cycles, and the defaults are derived from a clock-frequency parameter:

- glitch window of about 4 µs
- assert delay of about 20 µs
- hold of about 240 ms

A static strap input selects whether the output is active high or active low.

Top module: `brownout_stretch`

## Requirements
- R1: While power-on clear is applied, and right after it is released, the output is at its asserted level. With the supply flag low, the output releases after exactly HOLD_CYC rising clock edges counted from the first edge after release.
- R2: When `pol_hi_i` is 1, the asserted level of `rst_o` is 1 and the released level is 0. When `pol_hi_i` is 0, the asserted level is 0 and the released level is 1.
- R3: Let QUAL be the larger of ASSERT_CYC and FILTER_CYC+1. If `below_i` is sampled high on QUAL or more consecutive rising edges, starting at edge a, then `rst_o` shows the asserted level after edge a+QUAL+1.
- R4: A run of `below_i` highs shorter than QUAL edges leaves `rst_o` unchanged at every cycle. Every run of FILTER_CYC edges or fewer is therefore rejected.
- R5: Suppose the last high sample of a qualifying dip is at edge e. Reset then stays asserted through edge e+2+HOLD_CYC and is released after that edge.
- R6: A qualifying dip that starts while the hold timer is running restarts the hold. The release time then follows R5 for the new dip.
- R7: A short, non-qualifying dip during the hold neither extends nor shortens it.
- R8: With ASSERT_CYC above FILTER_CYC, the qualifying length is ASSERT_CYC. Otherwise it is FILTER_CYC+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| below_i | input | 1 | Supply-under-threshold flag from the comparator |
| pol_hi_i | input | 1 | Polarity strap: 1 gives active-high reset |
| rst_o | output | 1 | Reset output |

## Verification
The embedded properties make no assumption about when `below_i` changes. The two-flop synchronizer absorbs any timing of that input. The properties do take the polarity strap as static and the clear input as released cleanly. The stimulus therefore changes the strap only while power-on clear is applied. It moves `below_i` just after a clock edge, so the bench can count exactly which edge samples each change.

// File: rtl/brownout_stretch.sv
module brownout_stretch #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int FILTER_CYC = CLK_HZ / 250_000,
  parameter int ASSERT_CYC = CLK_HZ / 50_000,
  parameter int HOLD_CYC   = (CLK_HZ / 1000) * 240
) (
  input  logic clk,
  input  logic por_n,
  input  logic below_i,
  input  logic pol_hi_i,
  output logic rst_o
);
  localparam int QUAL = (ASSERT_CYC > FILTER_CYC) ? ASSERT_CYC : FILTER_CYC + 1;
  localparam int FW   = $clog2(QUAL + 1);
  localparam int HW   = $clog2(HOLD_CYC + 1);
  localparam logic [FW-1:0] QMAX = FW'(QUAL - 1);
  localparam logic [HW-1:0] HMAX = HW'(HOLD_CYC - 1);

  logic          s1, s2, low, active;
  logic [FW-1:0] fcnt;
  logic [HW-1:0] hcnt;
  logic          qualify;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) {s2, s1} <= 2'b00;
    else        {s2, s1} <= {s1, below_i};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)             fcnt <= '0;
    else if (!s2)           fcnt <= '0;
    else if (fcnt != QMAX)  fcnt <= fcnt + 1'b1;

  assign qualify = s2 && (fcnt == QMAX);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)       low <= 1'b0;
    else if (qualify) low <= 1'b1;
    else if (!s2)     low <= 1'b0;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      active <= 1'b1;
      hcnt   <= '0;
    end else if (qualify) begin
      active <= 1'b1;
      hcnt   <= '0;
    end else if (active && !low) begin
      if (hcnt == HMAX) begin
        active <= 1'b0;
        hcnt   <= '0;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end

  assign rst_o = active ~^ pol_hi_i;

  p_dip_asserts_r3: assert property (@(posedge clk) disable iff (!por_n)
    qualify |=> active);
  p_filter_clears_r4: assert property (@(posedge clk) disable iff (!por_n)
    (fcnt != '0 && !s2) |=> fcnt == '0);
  p_release_after_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
    $fell(active) |-> $past(hcnt) == HMAX);
  p_redip_restarts_r6: assert property (@(posedge clk) disable iff (!por_n)
    low |=> hcnt == '0);
  p_fcnt_bound_r8: assert property (@(posedge clk) disable iff (!por_n)
    fcnt <= QMAX);
  p_no_release_while_low_r3: assert property (@(posedge clk) disable iff (!por_n)
    low |-> active);
endmodule

// File: tb/test_brownout_stretch.sv
module test_brownout_stretch;
  localparam int HOLD = 10;
  localparam int QA = 4;
  localparam int QB = 6;

  logic clk = 1'b0, por_n = 1'b0, below = 1'b0, pol = 1'b1;
  logic rst_a, rst_b;
  int checks = 0, errors = 0, p = 0;
  int da[2], dn[2];
  int nd = 0;

  always #2.5 clk = ~clk;

  brownout_stretch #(.FILTER_CYC(3), .ASSERT_CYC(0), .HOLD_CYC(HOLD)) i_brownout_stretch (
    .clk(clk), .por_n(por_n), .below_i(below), .pol_hi_i(pol), .rst_o(rst_a));
  brownout_stretch #(.FILTER_CYC(2), .ASSERT_CYC(6), .HOLD_CYC(HOLD)) i_brownout_stretch_b (
    .clk(clk), .por_n(por_n), .below_i(below), .pol_hi_i(pol), .rst_o(rst_b));

  function automatic bit exp_on(int q);
    bit on = (p < HOLD);
    for (int k = 0; k < nd; k++)
      if (dn[k] >= q && p >= da[k] + q + 1 && p < da[k] + dn[k] + 2 + HOLD) on = 1'b1;
    return on;
  endfunction

  task automatic chk(string tag);
    logic ea, eb;
    ea = exp_on(QA) ? pol : ~pol;
    eb = exp_on(QB) ? pol : ~pol;
    checks += 2;
    if (rst_a !== ea) begin
      errors++;
      $display("FAIL %s dutA cyc %0d pol %0d got %b exp %b", tag, p, pol, rst_a, ea);
    end
    if (rst_b !== eb) begin
      errors++;
      $display("FAIL %s dutB cyc %0d pol %0d got %b exp %b", tag, p, pol, rst_b, eb);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk); #1;
    p++;
    chk(tag);
  endtask

  task automatic power_up(logic pv);
    @(posedge clk); #1;
    por_n = 1'b0; below = 1'b0; pol = pv; nd = 0; p = 0;
    #1;
    chk("R1 R2 por");
    @(posedge clk); #1;
    por_n = 1'b1;
    p = 0;
    chk("R1 R2 release");
    repeat (HOLD + 2) step("R1 R2 power window");
  endtask

  task automatic dip(int n, string tag);
    da[nd] = p + 1; dn[nd] = n; nd++;
    below = 1'b1;
    repeat (n) step(tag);
    below = 1'b0;
  endtask

  task automatic run_case(logic pv, int n1, int gap, int n2);
    power_up(pv);
    dip(n1, "R3 R4 R8 R2 dip");
    if (n2 > 0) begin
      repeat (gap) step("R5 gap");
      dip(n2, "R6 R7 redip");
    end
    repeat (2 * HOLD + QB + 8) step("R5 R6 R7 hold");
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog cyc %0d", p);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int pv = 0; pv < 2; pv++) begin
      for (int n = 1; n <= 8; n++) run_case(pv[0], n, 0, 0);
      for (int g = 3; g <= 9; g += 3) begin
        run_case(pv[0], 8, g, 2);
        run_case(pv[0], 8, g, 4);
        run_case(pv[0], 8, g, 7);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule